// File: doc/BRIEF.md
# Chainable Four-Channel Interval Counter

The block holds four 16-bit up-counters that share one register port. Each channel has a reload register, a start bit, an interrupt enable, a cascade bit and a two-bit prescale select. A channel in prescaled mode advances once every 2^shift system clock cycles. A channel in cascade mode advances once for each overflow of the channel below it, and it does so in the same clock edge as that overflow. When a counter wraps past 0xFFFF it takes its reload value and, if its interrupt enable is set, pulses its interrupt line for one cycle.

Software writes the reload value, then sets the start bit. The counter takes the reload value on that write. It spends one clock latching before it counts. Reads return the live count or the control settings. Line irq[t] belongs to channel t and is meant for system interrupt number 3 + t. The interrupt controller that takes these lines is not part of this block.

Top module: `quad_timer`

## Requirements
- R1: After reset every counter, reload and control register reads 0, and irq is 0.
- R2: Address bits [2:1] select the channel. With addr[0]=0 a write sets the reload value and a read returns the live counter. Writing the reload value never changes the counter. A write that sets start (control bit 7) on a stopped channel loads the reload value into the counter on that edge.
- R3: The first clock edge after a channel is started does not count.
- R4: In prescaled mode (control bit 2 clear), prescale select (control bits 1:0) values 0, 1, 2 and 3 give shifts 0, 6, 8 and 10. From the start write at edge E0, the count after edge Ek is reload + floor((k-1)/2^shift).
- R5: When a counter at 0xFFFF advances, it becomes the reload value.
- R6: With control bit 2 set, channel t>0 advances once on each edge where channel t-1 overflows. It overflows when it wraps and then takes its reload value, so a chain of channels can all overflow on one edge.
- R7: Channel 0 with control bit 2 set never counts.
- R8: irq[t] is high for exactly the one cycle after the edge on which channel t overflowed, and only if its interrupt enable (control bit 6) was set.
- R9: Clearing start freezes the counter at its value, and the value stays readable.
- R10: With addr[0]=1 a read returns start in bit 7, interrupt enable in bit 6, cascade in bit 2 and prescale select in bits 1:0. All other bits read as 0.
- R11: Writing start=1 to a channel that is already running does not reload it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | {channel, select}; select 0 = count/reload, 1 = control |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data for addr |
| irq | output | 4 | Per-channel one-cycle overflow pulses |

## Verification
The count read through addr is combinational, so a result becomes visible at the next falling edge after the rising edge that produced it. A start write shows the reload value after the write edge. The first increment arrives two edges later when the shift is 0, or 2^shift edges after the latch edge otherwise. An interrupt pulse appears one cycle after the overflowing edge, and cascade overflows appear on that same edge. The bench drives its inputs just after each rising edge and samples at the falling edge. It checks every sample against a behavioural model stepped on the rising edge. Directed checks land on the exact edge counts derived from R3 and R4.

// File: rtl/quad_timer.sv
module quad_timer #(
  parameter int CH = 4,
  parameter int CW = 16,
  localparam int AW = $clog2(CH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic [CH-1:0] irq
);

  localparam int PW  = 10;
  localparam int CHW = AW - 1;

  logic [CW-1:0] cnt [CH];
  logic [CW-1:0] rel [CH];
  logic [PW-1:0] pre [CH];
  logic [1:0]    psel[CH];
  logic [CH-1:0] en, run, ie, casc, inc, ovf;

  wire [CHW-1:0] wch    = addr[AW-1:1];
  wire           ctl_wr = wr_en & addr[0];
  wire           rel_wr = wr_en & ~addr[0];

  function automatic logic [PW-1:0] pmask(input logic [1:0] s);
    case (s)
      2'd0:    pmask = '0;
      2'd1:    pmask = PW'(63);
      2'd2:    pmask = PW'(255);
      default: pmask = PW'(1023);
    endcase
  endfunction

  always_comb begin
    logic carry;
    carry = 1'b0;
    for (int t = 0; t < CH; t++) begin
      inc[t] = en[t] & run[t] &
               (casc[t] ? carry : ((pre[t] & pmask(psel[t])) == pmask(psel[t])));
      ovf[t] = inc[t] & (&cnt[t]);
      carry  = ovf[t];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < CH; t++) begin
        cnt[t]  <= '0;
        rel[t]  <= '0;
        pre[t]  <= '0;
        psel[t] <= '0;
      end
      en   <= '0;
      run  <= '0;
      ie   <= '0;
      casc <= '0;
      irq  <= '0;
    end else begin
      for (int t = 0; t < CH; t++) begin
        irq[t] <= ovf[t] & ie[t];
        if (rel_wr && wch == CHW'(t))
          rel[t] <= wdata;
        if (ctl_wr && wch == CHW'(t)) begin
          en[t]   <= wdata[7];
          ie[t]   <= wdata[6];
          casc[t] <= wdata[2];
          psel[t] <= wdata[1:0];
          run[t]  <= wdata[7] & en[t];
        end else if (en[t]) begin
          run[t] <= 1'b1;
        end
        if (ctl_wr && wch == CHW'(t) && wdata[7] && !en[t]) begin
          cnt[t] <= rel[t];
          pre[t] <= '0;
        end else begin
          if (en[t] && run[t])
            pre[t] <= pre[t] + 1'b1;
          if (ovf[t])
            cnt[t] <= rel[t];
          else if (inc[t])
            cnt[t] <= cnt[t] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (addr[0])
      rdata = {{(CW-8){1'b0}}, en[wch], ie[wch], 3'b000, casc[wch], psel[wch]};
    else
      rdata = cnt[wch];
  end

  for (genvar g = 0; g < CH; g++) begin : g_chk
    logic hit_g;
    assign hit_g = ctl_wr && (wch == CHW'(g));

    p_hold_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!en[g] && !hit_g) |=> $stable(cnt[g]));

    p_latch_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en[g] && !run[g] && !hit_g) |=> $stable(cnt[g]));

    p_wrap_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf[g] && !hit_g) |=> (cnt[g] == $past(rel[g])));

    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] |-> $past(ie[g]));

    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en[g] && run[g] && !casc[g] && !hit_g && !(&cnt[g])) |=>
      ((cnt[g] == $past(cnt[g])) || (cnt[g] == $past(cnt[g]) + CW'(1))));

    if (g == 0) begin : g_ch0
      p_no_cascade_ch0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (casc[0] && !hit_g) |=> $stable(cnt[0]));
    end
  end

endmodule

// File: tb/test_quad_timer.sv
module test_quad_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  w_addr = '0;
  logic [15:0] wdata = '0;
  logic        hold = 1'b0;
  logic [2:0]  rot = '0;
  logic [2:0]  addr;
  logic [15:0] rdata;
  logic [3:0]  irq;

  int    tests = 0;
  int    fails = 0;
  bit    done = 1'b0;
  bit    live = 1'b0;
  string phase = "R1";

  assign addr = (wr_en || hold) ? w_addr : rot;

  always #10 clk = ~clk;
  always @(posedge clk) rot <= rot + 3'd1;

  quad_timer i_quad_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  int m_cnt[4], m_rel[4], m_psel[4], m_pre[4];
  bit m_en[4], m_run[4], m_ie[4], m_casc[4], m_irq[4], m_ovf[4];

  function automatic int shift_of(input int p);
    case (p)
      0: return 0;
      1: return 6;
      2: return 8;
      default: return 10;
    endcase
  endfunction

  function automatic int m_read(input logic [2:0] a);
    int c;
    c = int'(a[2:1]);
    if (a[0]) return (int'(m_en[c]) << 7) | (int'(m_ie[c]) << 6) |
                     (int'(m_casc[c]) << 2) | m_psel[c];
    return m_cnt[c];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < 4; t++) begin
        m_cnt[t] = 0; m_rel[t] = 0; m_psel[t] = 0; m_pre[t] = 0;
        m_en[t] = 0; m_run[t] = 0; m_ie[t] = 0; m_casc[t] = 0; m_irq[t] = 0;
      end
    end else begin
      bit carry;
      carry = 0;
      for (int t = 0; t < 4; t++) begin
        bit adv;
        if (m_casc[t]) adv = carry;
        else adv = ((m_pre[t] + 1) % (1 << shift_of(m_psel[t]))) == 0;
        adv = adv && m_en[t] && m_run[t];
        m_ovf[t] = adv && (m_cnt[t] == 65535);
        carry = m_ovf[t];
        m_irq[t] = m_ovf[t] && m_ie[t];
        if (m_en[t] && m_run[t]) m_pre[t]++;
        if (m_ovf[t]) m_cnt[t] = m_rel[t];
        else if (adv) m_cnt[t]++;
        if (m_en[t] && !m_run[t]) m_run[t] = 1;
      end
      if (wr_en) begin
        int c;
        c = int'(w_addr[2:1]);
        if (!w_addr[0]) m_rel[c] = int'(wdata);
        else begin
          if (wdata[7] && !m_en[c]) begin
            m_cnt[c] = m_rel[c]; m_run[c] = 0; m_pre[c] = 0;
          end
          if (!wdata[7]) m_run[c] = 0;
          m_en[c] = wdata[7]; m_ie[c] = wdata[6];
          m_casc[c] = wdata[2]; m_psel[c] = int'(wdata[1:0]);
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live && rst_n && !done) begin
      int mi;
      mi = int'(m_irq[0]) | (int'(m_irq[1]) << 1) | (int'(m_irq[2]) << 2) | (int'(m_irq[3]) << 3);
      chk({phase, " model rdata"}, int'(rdata), m_read(addr));
      chk({phase, " model irq"}, int'(irq), mi);
    end
  end

  task automatic wr(input int ch, input int sel, input int data);
    @(posedge clk); #2;
    wr_en = 1'b1; w_addr = 3'(ch * 2 + sel); wdata = 16'(data);
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic look(input int ch, input int sel);
    hold = 1'b1; w_addr = 3'(ch * 2 + sel);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int n1, mism, v;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    hold = 1'b1;
    for (int a = 0; a < 8; a++) begin
      w_addr = 3'(a);
      @(negedge clk);
      chk("R1 reset register", int'(rdata), 0);
    end
    chk("R1 reset irq", int'(irq), 0);
    live = 1'b1;

    phase = "R2";
    wr(0, 0, 'h0100);
    wr(0, 1, 'h0080);
    look(0, 0);
    @(negedge clk); chk("R2 start loads reload", int'(rdata), 'h0100);
    @(negedge clk); chk("R3 latch edge holds", int'(rdata), 'h0100);
    @(negedge clk); chk("R4 shift 0 first count", int'(rdata), 'h0101);
    wr(0, 0, 'h5555);
    look(0, 0);
    @(negedge clk); chk("R2 reload write keeps count", int'(rdata != 16'h5555), 1);
    phase = "R11";
    wr(0, 1, 'h0080);
    look(0, 0);
    @(negedge clk); chk("R11 restart no reload", int'(rdata != 16'h5555), 1);

    phase = "R10";
    wr(3, 1, 'h00FF);
    look(3, 1);
    @(negedge clk); chk("R10 control readback", int'(rdata), 'h00C7);
    wr(3, 1, 'h0000);
    wr(0, 1, 'h0000);

    phase = "R5";
    wr(0, 0, 'hFFF0);
    wr(0, 1, 'h00C1);
    look(0, 0);
    @(negedge clk);
    repeat (1024) @(negedge clk);
    chk("R4 shift 6 count at edge 1024", int'(rdata), 'hFFFF);
    chk("R8 no irq before wrap", int'(irq[0]), 0);
    @(negedge clk);
    chk("R5 wrap takes reload", int'(rdata), 'hFFF0);
    chk("R8 irq after wrap", int'(irq[0]), 1);
    @(negedge clk);
    chk("R8 irq one cycle", int'(irq[0]), 0);

    phase = "R8";
    wr(1, 0, 'hFFFF);
    wr(1, 1, 'h0080);
    n1 = 0;
    repeat (20) begin @(negedge clk); n1 += int'(irq[1]); end
    chk("R8 masked irq silent", n1, 0);
    wr(0, 1, 'h0000);
    wr(1, 1, 'h0000);

    phase = "R4";
    wr(1, 0, 'hFFFE);
    wr(1, 1, 'h0083);
    wr(2, 0, 'hFFFF);
    wr(2, 1, 'h00C2);
    hold = 1'b0;
    repeat (3000) @(negedge clk);
    wr(1, 1, 'h0000);
    wr(2, 1, 'h0000);

    phase = "R7";
    wr(0, 0, 'h0042);
    wr(0, 1, 'h0084);
    look(0, 0);
    repeat (40) @(negedge clk);
    chk("R7 channel 0 cascade idle", int'(rdata), 'h0042);
    wr(0, 1, 'h0000);

    phase = "R6";
    wr(1, 0, 'hFFFE);
    wr(1, 1, 'h00C4);
    wr(2, 0, 'hFFFF);
    wr(2, 1, 'h00C4);
    wr(3, 0, 'h0000);
    wr(3, 1, 'h0084);
    wr(0, 0, 'hFFFC);
    wr(0, 1, 'h0080);
    hold = 1'b0;
    n1 = 0; mism = 0;
    repeat (200) begin
      @(negedge clk);
      n1 += int'(irq[1]);
      if (irq[2] != irq[1]) mism++;
    end
    chk("R6 cascade overflow count", n1, 24);
    chk("R6 chained same-edge overflow", mism, 0);

    phase = "R9";
    wr(0, 1, 'h0000);
    look(0, 0);
    @(negedge clk); v = int'(rdata);
    repeat (20) @(negedge clk);
    chk("R9 stopped count frozen", int'(rdata), v);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule